// File: doc/BRIEF.md
# Interleaved Four-Bank Block Reader

This block refills one four-word cache block from four memory banks that are interleaved by word: word i of every block is held in bank i. A requester presents a block address with a request; once the block reader accepts it, the address goes to all four banks in a single cycle. The banks then run their long reads side by side. When every bank holds its word, the block reader returns the four words over a 32-bit bus, one word per cycle, bank 0 first.

Each returned word has a valid strobe and a two-bit index. The last word also carries a one-cycle done pulse. A counter reports the miss penalty, which is the number of cycles from acceptance up to and including the done cycle. With the default bank latency of 25 cycles, the penalty is 1 + 25 + 3 + 1 = 30 cycles, against about a hundred cycles for four serial bank reads. The bank latency is a parameter. The banks here are read-only models whose contents are a fixed function of the word address.

Top module: `ilv_block_reader`

## Requirements
- R1: After reset, ready_o is 1, rvalid_o is 0, done_o is 0 and penalty_o is 0.
- R2: A request is accepted at a rising clock edge where req_i and ready_o are both 1. ready_o is 0 from the cycle after acceptance through the done cycle, and it is 1 again in the cycle after done_o.
- R3: The block address is captured at acceptance. While the reader is busy, req_i and blk_addr_i have no effect: the words returned belong to the captured address, and no further words follow the done pulse.
- R4: The captured address reaches all four banks in the first busy cycle, and the banks read in parallel. Word 0 appears in busy cycle LAT+2, where LAT is the bank latency.
- R5: The four words appear on consecutive cycles with rvalid_o = 1, and ridx_o takes the values 0, 1, 2, 3 in that order.
- R6: The word with index i of block address A equals ((A * 4 + i) taken as a 32-bit word address) XOR 32'h5A5A_C3C3, and it is read from bank i.
- R7: done_o is 1 for exactly one cycle, in the same cycle as the word with index 3, and at no other time.
- R8: penalty_o counts the busy cycles of the current request, with the first busy cycle counting as 1. In the done cycle it equals 1 + LAT + 3 + 1, and it holds that value until the next acceptance.
- R9: A new request held on req_i is accepted in the first cycle that ready_o is 1 again after done_o. Back-to-back blocks therefore have exactly one idle cycle between them.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| req_i | input | 1 | Block read request |
| blk_addr_i | input | AW | Block address, in units of four-word blocks |
| ready_o | output | 1 | Idle and able to accept a request |
| rvalid_o | output | 1 | A returned word is on rdata_o |
| ridx_o | output | 2 | Index of the word inside the block |
| rdata_o | output | 32 | Returned word |
| done_o | output | 1 | Last word of the block is being returned |
| penalty_o | output | PW | Busy cycles of the current or last request |

## Verification
The assertions assume that the banks are only started by the reader. They also assume that a request arrives only as a req_i level, sampled when ready_o is 1. Under those assumptions the banks are always ready by the time the words stream out, and the index advances by one on every valid cycle.

The bench changes req_i and blk_addr_i only at falling edges, so every request is a clean synchronous level. On purpose, it raises req_i with a different address in the middle of a transfer. This shows that the busy window ignores such traffic. Every returned word is compared against a queue of words computed from the address formula alone.

// File: rtl/ilv_pkg.sv
package ilv_pkg;

    localparam int unsigned NBANK  = 4;
    localparam int unsigned WORD_W = 32;
    localparam logic [WORD_W-1:0] CONTENT_MASK = 32'h5A5A_C3C3;

    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_ADDR = 2'd1,
        ST_WAIT = 2'd2,
        ST_XFER = 2'd3
    } rd_state_e;

    // contents of the modelled banks: word address XOR a fixed mask
    function automatic logic [WORD_W-1:0] bank_word(input logic [WORD_W-1:0] blk,
                                                    input logic [1:0]        bank);
        logic [WORD_W-1:0] wa;
        wa = (blk << 2) | {{(WORD_W-2){1'b0}}, bank};
        return wa ^ CONTENT_MASK;
    endfunction

endpackage

// File: rtl/ilv_bank.sv
module ilv_bank
    import ilv_pkg::*;
#(
    parameter int unsigned AW      = 30,
    parameter int unsigned LAT     = 25,
    parameter int unsigned BANK_ID = 0
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              go_i,
    input  logic [AW-1:0]     addr_i,
    output logic              rdy_o,
    output logic [WORD_W-1:0] data_o
);

    localparam int unsigned CW = (LAT < 2) ? 1 : $clog2(LAT);

    typedef struct packed {
        logic              armed;
        logic [CW-1:0]     cnt;
        logic [WORD_W-1:0] data;
    } bank_st_t;

    bank_st_t s_d, s_q;

    always_comb begin
        s_d = s_q;
        if (go_i) begin
            s_d.armed = 1'b1;
            s_d.cnt   = CW'(LAT - 1);
            s_d.data  = bank_word(WORD_W'(addr_i), 2'(BANK_ID));
        end else if (s_q.cnt != '0) begin
            s_d.cnt = s_q.cnt - 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) s_q <= '0;
        else        s_q <= s_d;
    end

    assign rdy_o  = s_q.armed && (s_q.cnt == '0);
    assign data_o = s_q.data;

    // R4
    bank_busy_after_go_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (go_i && (LAT > 1)) |=> !rdy_o);

    // R6
    bank_data_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (rdy_o && !go_i) |=> (rdy_o && $stable(data_o)));

endmodule

// File: rtl/ilv_seq.sv
module ilv_seq
    import ilv_pkg::*;
#(
    parameter int unsigned AW = 30
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          req_i,
    input  logic [AW-1:0] addr_i,
    input  logic          banks_rdy_i,
    output logic          ready_o,
    output logic          go_o,
    output logic [AW-1:0] bank_addr_o,
    output logic          rvalid_o,
    output logic [1:0]    idx_o,
    output logic          done_o,
    output logic          accept_o,
    output logic          busy_o
);

    typedef struct packed {
        rd_state_e     st;
        logic [1:0]    idx;
        logic [AW-1:0] addr;
    } seq_st_t;

    seq_st_t s_d, s_q;

    always_comb begin
        s_d = s_q;
        unique case (s_q.st)
            ST_IDLE: if (req_i) begin
                s_d.st   = ST_ADDR;
                s_d.addr = addr_i;
                s_d.idx  = '0;
            end
            ST_ADDR: s_d.st = ST_WAIT;
            ST_WAIT: if (banks_rdy_i) begin
                s_d.st  = ST_XFER;
                s_d.idx = '0;
            end
            ST_XFER: begin
                if (s_q.idx == 2'd3) s_d.st = ST_IDLE;
                else                 s_d.idx = s_q.idx + 2'd1;
            end
            default: s_d.st = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) s_q <= '{st: ST_IDLE, idx: '0, addr: '0};
        else        s_q <= s_d;
    end

    assign ready_o     = (s_q.st == ST_IDLE);
    assign accept_o    = ready_o && req_i;
    assign busy_o      = !ready_o;
    assign go_o        = (s_q.st == ST_ADDR);
    assign bank_addr_o = s_q.addr;
    assign rvalid_o    = (s_q.st == ST_XFER);
    assign idx_o       = s_q.idx;
    assign done_o      = rvalid_o && (s_q.idx == 2'd3);

    // R2
    accept_drops_ready_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (req_i && ready_o) |=> (!ready_o && go_o));

    // R2
    done_restores_ready_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |=> ready_o);

    // R4
    go_single_cycle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        go_o |=> !go_o);

    // R5
    idx_advance_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (rvalid_o && idx_o != 2'd3) |=> (rvalid_o && idx_o == $past(idx_o) + 2'd1));

    // R3
    addr_held_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!ready_o && !done_o) |=> $stable(bank_addr_o));

endmodule

// File: rtl/ilv_pen_ctr.sv
module ilv_pen_ctr #(
    parameter int unsigned PW = 6
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          accept_i,
    input  logic          busy_i,
    input  logic          done_i,
    output logic [PW-1:0] pen_o
);

    typedef struct packed {
        logic [PW-1:0] cnt;
    } pen_st_t;

    pen_st_t s_d, s_q;

    always_comb begin
        s_d = s_q;
        if (accept_i)              s_d.cnt = PW'(1);
        else if (busy_i && !done_i) s_d.cnt = s_q.cnt + 1'b1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) s_q <= '0;
        else        s_q <= s_d;
    end

    assign pen_o = s_q.cnt;

    // R8
    pen_hold_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy_i && !accept_i) |=> $stable(pen_o));

endmodule

// File: rtl/ilv_block_reader.sv
module ilv_block_reader
    import ilv_pkg::*;
#(
    parameter int unsigned AW  = 30,
    parameter int unsigned LAT = 25,
    parameter int unsigned PW  = $clog2(LAT + 6)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_i,
    input  logic [AW-1:0]     blk_addr_i,
    output logic              ready_o,
    output logic              rvalid_o,
    output logic [1:0]        ridx_o,
    output logic [WORD_W-1:0] rdata_o,
    output logic              done_o,
    output logic [PW-1:0]     penalty_o
);

    localparam int unsigned PEN_TOTAL = 1 + LAT + (NBANK - 1) + 1;

    logic                          go;
    logic [AW-1:0]                 bank_addr;
    logic [NBANK-1:0]              bank_rdy;
    logic [NBANK-1:0][WORD_W-1:0]  bank_data;
    logic                          accept;
    logic                          busy;

    ilv_seq #(.AW(AW)) u_seq (
        .clk         (clk),
        .rst_n       (rst_n),
        .req_i       (req_i),
        .addr_i      (blk_addr_i),
        .banks_rdy_i (&bank_rdy),
        .ready_o     (ready_o),
        .go_o        (go),
        .bank_addr_o (bank_addr),
        .rvalid_o    (rvalid_o),
        .idx_o       (ridx_o),
        .done_o      (done_o),
        .accept_o    (accept),
        .busy_o      (busy)
    );

    for (genvar b = 0; b < NBANK; b++) begin : g_bank
        ilv_bank #(.AW(AW), .LAT(LAT), .BANK_ID(b)) u_bank (
            .clk    (clk),
            .rst_n  (rst_n),
            .go_i   (go),
            .addr_i (bank_addr),
            .rdy_o  (bank_rdy[b]),
            .data_o (bank_data[b])
        );
    end

    assign rdata_o = bank_data[ridx_o];

    ilv_pen_ctr #(.PW(PW)) u_pen (
        .clk      (clk),
        .rst_n    (rst_n),
        .accept_i (accept),
        .busy_i   (busy),
        .done_i   (done_o),
        .pen_o    (penalty_o)
    );

    // R4
    banks_ready_when_streaming_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rvalid_o |-> (&bank_rdy));

    // R8
    penalty_at_done_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |-> (penalty_o == PW'(PEN_TOTAL)));

    // R7
    done_only_last_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |-> (rvalid_o && ridx_o == 2'd3));

endmodule

// File: tb/sim_ilv_block_reader.sv
module sim_ilv_block_reader;

    localparam int unsigned AW    = 30;
    localparam int unsigned LAT   = 25;
    localparam int unsigned PW    = $clog2(LAT + 6);
    localparam int unsigned TOTAL = 1 + LAT + 3 + 1;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          req_i = 1'b0;
    logic [AW-1:0] blk_addr_i = '0;
    logic          ready_o, rvalid_o, done_o;
    logic [1:0]    ridx_o;
    logic [31:0]   rdata_o;
    logic [PW-1:0] penalty_o;

    int errors = 0;
    int checks = 0;
    int busy_cnt = 0;
    int words_seen = 0;
    logic [33:0] expq[$];

    always #5 clk = ~clk;

    ilv_block_reader #(.AW(AW), .LAT(LAT), .PW(PW)) u0 (
        .clk(clk), .rst_n(rst_n), .req_i(req_i), .blk_addr_i(blk_addr_i),
        .ready_o(ready_o), .rvalid_o(rvalid_o), .ridx_o(ridx_o),
        .rdata_o(rdata_o), .done_o(done_o), .penalty_o(penalty_o)
    );

    function automatic logic [31:0] model_word(input logic [AW-1:0] a, input int i);
        logic [31:0] wa;
        wa = 32'(a) * 32'd4 + 32'(i);
        return wa ^ 32'h5A5A_C3C3;
    endfunction

    task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    // driver: waits for ready, pushes expected words, raises the request
    task automatic issue(input logic [AW-1:0] a);
        while (!ready_o) @(negedge clk);
        for (int i = 0; i < 4; i++) expq.push_back({2'(i), model_word(a, i)});
        req_i = 1'b1;
        blk_addr_i = a;
        @(negedge clk);
        req_i = 1'b0;
        blk_addr_i = ~a;
    endtask

    task automatic wait_idle();
        @(negedge clk);
        while (!ready_o) @(negedge clk);
    endtask

    // monitor
    always @(negedge clk) begin
        if (rst_n) begin
            if (!ready_o) busy_cnt++;
            if (rvalid_o) begin
                words_seen++;
                if (expq.size() == 0) begin
                    check("R3 unexpected word", {62'd0, ridx_o}, 64'hFFFF);
                end else begin
                    logic [33:0] e;
                    e = expq.pop_front();
                    check("R5 word index", 64'(ridx_o), 64'(e[33:32]));
                    check("R6 word data", 64'(rdata_o), 64'(e[31:0]));
                    if (ridx_o == 2'd0)
                        check("R4 first word busy cycle", 64'(busy_cnt), 64'(LAT + 2));
                    check("R7 done with last word", 64'(done_o), 64'(ridx_o == 2'd3));
                end
            end else begin
                if (done_o) check("R7 done without word", 64'(done_o), 64'd0);
            end
            if (done_o) begin
                check("R8 penalty at done", 64'(penalty_o), 64'(TOTAL));
                check("R2 busy span", 64'(busy_cnt), 64'(TOTAL));
            end
            if (ready_o) busy_cnt = 0;
        end
    end

    initial begin
        repeat (200000) @(posedge clk);
        errors++;
        checks++;
        $display("FAIL watchdog actual=expired expected=finished");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        // R1 reset state
        check("R1 ready", 64'(ready_o), 64'd1);
        check("R1 rvalid", 64'(rvalid_o), 64'd0);
        check("R1 done", 64'(done_o), 64'd0);
        check("R1 penalty", 64'(penalty_o), 64'd0);
        rst_n = 1'b1;
        @(negedge clk);

        issue(30'd0);
        check("R2 ready low after accept", 64'(ready_o), 64'd0);
        wait_idle();
        check("R2 ready after done", 64'(ready_o), 64'd1);
        check("R8 penalty held", 64'(penalty_o), 64'(TOTAL));

        issue(30'd1);
        wait_idle();
        issue(30'h3FFF_FFFF);
        wait_idle();

        // R3: request with another address while busy is ignored
        issue(30'h0012_3456);
        repeat (5) @(negedge clk);
        req_i = 1'b1;
        blk_addr_i = 30'h0ABC_DEF0;
        repeat (3) @(negedge clk);
        req_i = 1'b0;
        wait_idle();
        words_seen = 0;
        repeat (LAT + 8) @(negedge clk);
        check("R3 no extra words after done", 64'(words_seen), 64'd0);
        check("R3 queue drained", 64'(expq.size()), 64'd0);

        // R9: back-to-back with req held
        for (int i = 0; i < 4; i++) expq.push_back({2'(i), model_word(30'h155, i)});
        for (int i = 0; i < 4; i++) expq.push_back({2'(i), model_word(30'h2AA, i)});
        req_i = 1'b1;
        blk_addr_i = 30'h155;
        @(negedge clk);
        blk_addr_i = 30'h2AA;
        while (!done_o) @(negedge clk);
        @(negedge clk);
        check("R9 ready one cycle after done", 64'(ready_o), 64'd1);
        @(negedge clk);
        req_i = 1'b0;
        check("R9 second block accepted", 64'(ready_o), 64'd0);
        check("R8 penalty restarts at 1", 64'(penalty_o), 64'd1);
        wait_idle();
        repeat (2) @(negedge clk);
        check("R5 all words returned", 64'(expq.size()), 64'd0);

        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule